// File: doc/BRIEF.md
# Serial Flash Streaming Read Host

This block is the host end of a serial flash link that fetches a run of consecutive bytes. A single request carries a 24-bit start address, a byte count and a speed class. The controller drops chip select, produces SCK from the system clock through a divider, and sends a command byte, the address and any padding bytes the speed class needs. It then clocks in the returned bytes and hands each one to a valid/ready output stream. The link runs in SPI mode 0: SCK rests low, the host changes its serial output after a falling edge, and both sides sample on the rising edge.

The byte count may carry the read past the top of the 24-bit address space. The device wraps to address zero by itself, so the host only counts bytes and does no address arithmetic. Back-pressure works as follows. A completed byte stays on `rd_data` with `rd_valid` high until `rd_ready` is seen high on a clock edge. While a byte is still waiting there, the controller holds SCK low before the first rising edge of the next byte, with chip select still low. No data is lost and no limit applies to how long the consumer may stall.

Top module: `spi_rd_host`

## Requirements
- R1: The command byte follows `req_speed`. Code 0 sends 8'h03 with no padding byte. Code 1 sends 8'h0B and one padding byte. Codes 2 and 3 both send 8'h1B and two padding bytes.
- R2: The 24-bit address goes out MSB first, directly after the command byte, and every padding bit is driven as 0.
- R3: SCK is low whenever chip select is high. The host serial output never changes while SCK is high, and input data is sampled on rising SCK edges.
- R4: Exactly `req_len`+1 bytes are delivered, each assembled MSB first. Byte k matches the device byte at (start address + k) modulo 2^24.
- R5: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` stays stable. A waiting byte blocks every further rising SCK edge.
- R6: In the cycle after a request is accepted, chip select is low and `busy` is high. `busy` and `req_ready` are never high together. `busy` falls when chip select rises after the last byte.
- R7: After chip select rises, `req_ready` stays low for at least two SCK periods, that is 4*(`clk_div`+1) system cycles.
- R8: Each SCK half period lasts `clk_div`+1 system cycles. The divider value is captured when the request is accepted.
- R9: After reset, chip select is high, SCK is low, `busy` and `rd_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_addr | input | 24 | Start byte address |
| req_len | input | CNT_W | Number of bytes minus one |
| req_speed | input | 2 | Speed class code (see R1) |
| clk_div | input | DIV_W | SCK half period minus one, in system cycles |
| busy | output | 1 | Transaction in progress, chip select low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Host serial data out |
| spi_miso | input | 1 | Device serial data in |
| rd_valid | output | 1 | Output byte present |
| rd_ready | input | 1 | Consumer accepts the byte |
| rd_data | output | 8 | Received byte |

## Verification
The properties assume that `spi_miso` changes only while SCK is low, and that the consumer does not treat `rd_valid` as a combinational function of `rd_ready`. The request fields are held steady for the one cycle in which they are accepted. The bench device model changes its data line only on falling SCK edges. Requests are driven away from the active clock edge and are presented only while `req_ready` is high. Consumer readiness is drawn at random, or held low for a directed stall window, and it always comes back high so that every transfer can finish.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

  typedef enum logic [1:0] {
    SPD_LOW  = 2'd0,
    SPD_STD  = 2'd1,
    SPD_FAST = 2'd2,
    SPD_ALT  = 2'd3
  } speed_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } state_t;

  localparam int ADDR_W  = 24;
  localparam int HDR_MAX = 48;
  localparam int HDR_CW  = $clog2(HDR_MAX + 1);

  function automatic logic [7:0] cmd_of(input logic [1:0] spd);
    case (spd)
      SPD_LOW: cmd_of = 8'h03;
      SPD_STD: cmd_of = 8'h0B;
      default: cmd_of = 8'h1B;
    endcase
  endfunction

  function automatic logic [HDR_CW-1:0] hdr_bits_of(input logic [1:0] spd);
    case (spd)
      SPD_LOW: hdr_bits_of = HDR_CW'(32);
      SPD_STD: hdr_bits_of = HDR_CW'(40);
      default: hdr_bits_of = HDR_CW'(48);
    endcase
  endfunction

endpackage

// File: rtl/spi_rd_tick.sv
module spi_rd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = en && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!en)     cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_rd_hdr.sv
module spi_rd_hdr
  import spi_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [7:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HDR_CW-1:0] nbits,
  input  logic              shift,
  output logic              mosi,
  output logic              last
);
  localparam int PAD_W = HDR_MAX - 8 - ADDR_W;

  logic [HDR_MAX-1:0] sreg_q;
  logic [HDR_CW-1:0]  rem_q;

  assign mosi = (rem_q != '0) ? sreg_q[HDR_MAX-1] : 1'b0;
  assign last = (rem_q == HDR_CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      rem_q  <= '0;
    end else if (load) begin
      sreg_q <= {cmd, addr, {PAD_W{1'b0}}};
      rem_q  <= nbits;
    end else if (shift && rem_q != '0) begin
      sreg_q <= {sreg_q[HDR_MAX-2:0], 1'b0};
      rem_q  <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/spi_rd_rx.sv
module spi_rd_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       sample,
  input  logic       miso,
  input  logic       rd_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       at_byte_start
);
  logic [2:0] idx_q;
  logic [6:0] part_q;

  assign at_byte_start = (idx_q == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      part_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (clr) begin
        idx_q <= '0;
      end else if (sample) begin
        part_q <= {part_q[5:0], miso};
        idx_q  <= idx_q + 1'b1;
        if (idx_q == 3'd7) begin
          rd_data  <= {part_q, miso};
          rd_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_rd_host.sv
module spi_rd_host
  import spi_rd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_len,
  input  logic [1:0]        req_speed,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              busy,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data
);
  state_t           st_q;
  logic             sck_q;
  logic             cs_n_q;
  logic             in_data_q;
  logic [CNT_W-1:0] left_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       gap_q;

  logic tick, rise, fall, stall, tick_en, accept;
  logic hdr_last, byte_start;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign busy      = (st_q == ST_XFER);
  assign spi_sck   = sck_q;
  assign spi_cs_n  = cs_n_q;

  assign stall   = in_data_q && !sck_q && byte_start && rd_valid;
  assign tick_en = ((st_q == ST_XFER) && !stall) || (st_q == ST_GAP);
  assign rise    = tick && !sck_q && (st_q == ST_XFER);
  assign fall    = tick && sck_q && (st_q == ST_XFER);

  spi_rd_tick #(.DIV_W(DIV_W)) tick_i (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (tick_en),
    .div  (div_q),
    .tick (tick)
  );

  spi_rd_hdr hdr_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .cmd  (cmd_of(req_speed)),
    .addr (req_addr),
    .nbits(hdr_bits_of(req_speed)),
    .shift(fall && !in_data_q),
    .mosi (spi_mosi),
    .last (hdr_last)
  );

  spi_rd_rx rx_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (accept),
    .sample       (rise && in_data_q),
    .miso         (spi_miso),
    .rd_ready     (rd_ready),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .at_byte_start(byte_start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sck_q     <= 1'b0;
      cs_n_q    <= 1'b1;
      in_data_q <= 1'b0;
      left_q    <= '0;
      div_q     <= '0;
      gap_q     <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q      <= ST_XFER;
            cs_n_q    <= 1'b0;
            sck_q     <= 1'b0;
            in_data_q <= 1'b0;
            left_q    <= req_len;
            div_q     <= clk_div;
          end
        end
        ST_XFER: begin
          if (rise) sck_q <= 1'b1;
          if (fall) begin
            sck_q <= 1'b0;
            if (!in_data_q) begin
              if (hdr_last) in_data_q <= 1'b1;
            end else if (byte_start) begin
              if (left_q == '0) begin
                st_q      <= ST_GAP;
                cs_n_q    <= 1'b1;
                in_data_q <= 1'b0;
                gap_q     <= '0;
              end else begin
                left_q <= left_q - 1'b1;
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            gap_q <= gap_q + 1'b1;
            if (gap_q == 2'd3) st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_rd_host_chk.sv
module spi_rd_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       busy,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  assert_accept_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!spi_cs_n && busy));

  assert_busy_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_sck_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_mosi_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));

  assert_hold_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !req_ready);
endmodule

bind spi_rd_host spi_rd_host_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .busy     (busy),
  .spi_cs_n (spi_cs_n),
  .spi_sck  (spi_sck),
  .spi_mosi (spi_mosi),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data)
);

// File: tb/spi_rd_host_tb.sv
`timescale 1ns/1ps
module spi_rd_host_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [1:0]  req_speed = '0;
  logic [7:0]  clk_div = '0;
  logic        busy;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data;

  always #2 clk = ~clk;

  spi_rd_host dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_speed(req_speed), .clk_div(clk_div),
    .busy(busy), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] dev_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic int hdr_len(input logic [7:0] op);
    case (op)
      8'h0B:   return 40;
      8'h1B:   return 48;
      default: return 32;
    endcase
  endfunction

  function automatic logic [7:0] exp_cmd(input logic [1:0] sp);
    case (sp)
      2'd0:    return 8'h03;
      2'd1:    return 8'h0B;
      default: return 8'h1B;
    endcase
  endfunction

  always @(negedge clk) cyc <= cyc + 1;

  // device model
  int          rcnt = 0;
  int          nrise = 0;
  int          r0 = 0, r1 = 0;
  logic [7:0]  m_op = '0;
  logic [23:0] m_addr = '0;
  logic        m_pad = 1'b0;

  always @(negedge spi_cs_n) begin
    rcnt = 0; m_op = '0; m_addr = '0; m_pad = 1'b0;
  end

  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      if (rcnt < 8)                 m_op   = {m_op[6:0], spi_mosi};
      else if (rcnt < 32)           m_addr = {m_addr[22:0], spi_mosi};
      else if (rcnt < hdr_len(m_op)) m_pad = m_pad | spi_mosi;
      if (rcnt == 0) r0 = cyc;
      if (rcnt == 1) r1 = cyc;
      rcnt++;
      nrise++;
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && rcnt >= hdr_len(m_op)) begin
      int idx;
      logic [7:0] b;
      idx = rcnt - hdr_len(m_op);
      b = dev_byte(m_addr + 24'(idx / 8));
      spi_miso = b[7 - (idx % 8)];
    end
  end

  // consumer
  int          rmode = 0;
  int          got = 0;
  logic [23:0] exp_base = '0;
  bit          hold_chk = 1'b0;
  logic [7:0]  held = '0;

  always @(negedge clk) begin
    logic r;
    if (hold_chk)
      check(rd_valid && rd_data == held, "R5 byte held under back-pressure",
            {rd_valid, rd_data}, {1'b1, held});
    case (rmode)
      0: r = ($urandom_range(0, 3) != 0);
      1: r = 1'b1;
      default: r = 1'b0;
    endcase
    rd_ready = r;
    hold_chk = rd_valid && !r;
    held = rd_data;
    if (rd_valid && r) begin
      check(rd_data == dev_byte(exp_base + 24'(got)), "R4 data byte",
            rd_data, dev_byte(exp_base + 24'(got)));
      got++;
    end
  end

  task automatic start_req(input logic [23:0] a, input int n, input logic [1:0] sp,
                           input logic [7:0] dv);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_base = a; got = 0;
    req_valid = 1'b1; req_addr = a; req_len = 16'(n - 1); req_speed = sp; clk_div = dv;
    @(negedge clk);
    req_valid = 1'b0;
    check(!spi_cs_n && busy, "R6 cs low and busy after accept", {spi_cs_n, busy}, 2'b01);
  endtask

  task automatic finish_req(input logic [23:0] a, input int n, input logic [1:0] sp,
                            input logic [7:0] dv);
    int k;
    if (!spi_cs_n) @(posedge spi_cs_n);
    @(negedge clk);
    check(m_op == exp_cmd(sp), "R1 command byte", m_op, exp_cmd(sp));
    check(m_addr == a, "R2 address", m_addr, a);
    check(!m_pad, "R2 padding driven zero", m_pad, 0);
    check(!busy, "R6 busy low after cs rise", busy, 0);
    check((r1 - r0) == 2 * (dv + 1), "R8 sck period", r1 - r0, 2 * (dv + 1));
    k = 1;
    while (!req_ready) begin @(negedge clk); k++; end
    check(k >= 4 * (dv + 1), "R7 cs high time", k, 4 * (dv + 1));
    while (got < n) @(negedge clk);
    repeat (4) @(negedge clk);
    check(got == n && !rd_valid, "R4 byte count", got, n);
  endtask

  task automatic do_read(input logic [23:0] a, input int n, input logic [1:0] sp,
                         input logic [7:0] dv);
    start_req(a, n, sp, dv);
    finish_req(a, n, sp, dv);
  endtask

  task automatic run_all();
    int nr;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(spi_cs_n && !spi_sck && !busy && !rd_valid && req_ready, "R9 reset state",
          {spi_cs_n, spi_sck, busy, rd_valid, req_ready}, 5'b10001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(spi_cs_n && !spi_sck && req_ready, "R9 state after reset release",
          {spi_cs_n, spi_sck, req_ready}, 3'b101);
    // directed corners
    rmode = 1;
    do_read(24'h000100, 1, 2'd0, 8'd0);          // R1 low class, single byte
    do_read(24'hFFFFFE, 5, 2'd1, 8'd1);          // R4 wrap past top
    do_read(24'h123456, 3, 2'd3, 8'd5);          // R1 code 3 uses fast command
    // R5 stall: hold consumer off, no SCK rises allowed
    rmode = 2;
    start_req(24'h00ABCD, 2, 2'd2, 8'd0);
    while (!rd_valid) @(negedge clk);
    @(negedge clk);
    nr = nrise;
    repeat (100) @(negedge clk);
    check(nrise == nr && !spi_sck && !spi_cs_n && rd_valid, "R5 sck paused while byte waits",
          nrise - nr, 0);
    rmode = 1;
    finish_req(24'h00ABCD, 2, 2'd2, 8'd0);
    // random mix
    rmode = 0;
    for (int i = 0; i < 16; i++) begin
      logic [23:0] a;
      a = (i % 4 == 0) ? (24'hFFFFF8 + 24'($urandom_range(0, 7))) : 24'($urandom);
      do_read(a, $urandom_range(1, 6), 2'($urandom_range(0, 3)), 8'($urandom_range(0, 3)));
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule